// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

The block is a full-duplex asynchronous serial transmitter and receiver that sits behind a four-location, byte-wide register bus. One data location serves both directions. A write there loads the outgoing character and starts its frame at once. A read there returns the last character received. A control location sets the character length (7 or 8 bits), the parity rule, one or two stop bits, and separate enables for the transmitter and the receiver. A status location reports parity, framing and overrun errors, and all of them clear when software reads it. A divider location sets the 16x sample clock.

The receiver synchronises the serial input and samples it at 16 times the bit rate. It confirms a start bit half a bit after the falling edge, then samples each data bit at its centre, least significant bit first. A completed character moves from a private shift register into the receive buffer in one transfer. Each direction drives a one-cycle completion pulse for an interrupt controller. The register bus is a plain strobe interface with no back-pressure: each access completes in the cycle it is presented. Software reads the busy flag before it writes new transmit data.

Top module: `sio_port`

## Requirements
- R1: After reset the data location reads 0xFF, the control location reads 0x00, the status location reads 0x00, `txd` is high and `tx_busy` is low.
- R2: Location 0 is data, 1 is control, 2 is status and 3 is the divider. With transmit enabled, a write to location 0 sends a low start bit and then the data bits LSB first. Each bit lasts 16*(divider+1) clock cycles. Between frames the line is high.
- R3: Control bits 5:4 pick the parity: 00 none, 01 a constant 0, 10 odd (the data plus parity hold an odd number of ones), 11 even. The transmitter appends the bit after the data and the receiver checks it.
- R4: Control bit 3 set gives two high stop bits, clear gives one. `tx_busy` stays high for the whole frame, stop bits included.
- R5: Control bit 2 clear selects 7-bit characters: the transmitter sends bits 0 to 6 only, and parity covers those seven bits.
- R6: In 7-bit mode the receiver places bits 0 to 6 in the buffer and bit 7 of the buffer reads 0.
- R7: A data write while `tx_busy` is high is ignored, and the frame in flight is sent unchanged. Status bit 3 mirrors `tx_busy`.
- R8: The receiver accepts a start bit only if the line is still low half a bit after the falling edge. A shorter low pulse produces no character.
- R9: Status bit 2 flags a parity error and bit 1 flags a low stop bit. Bit 0 flags a character completed while the buffer still held an unread one, and the new character replaces it. A status read clears bits 2:0.
- R10: When a transfer into the buffer and a register read fall in the same cycle, the read returns the old contents. A data read in that cycle prevents the overrun flag. A status read in that cycle does not clear the flags the transfer sets.
- R11: `irq_tx` pulses for one cycle as `tx_busy` falls. `irq_rx` pulses for one cycle in the cycle before the received character lands in the buffer.
- R12: With control bit 7 clear, data writes start nothing. With control bit 6 clear, the receiver ignores the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register location |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| tx_busy | output | 1 | A transmit frame is in progress |
| irq_tx | output | 1 | Transmit-complete pulse |
| irq_rx | output | 1 | Receive-complete pulse |

## Verification
Software reads can land in the same cycle as a receive transfer into the buffer and status flags. `irq_rx` is high in exactly that cycle, so the bench waits for it at a falling clock edge and presents a read in the same cycle. One case reads the data location while the buffer is still full: it expects the older character and no overrun afterwards. The other case reads the status location while a parity error is arriving: it expects the old, clear flags, and then a parity flag that survives into the next status read.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] LOC_DATA = 2'd0;
  localparam logic [1:0] LOC_CTRL = 2'd1;
  localparam logic [1:0] LOC_STAT = 2'd2;
  localparam logic [1:0] LOC_DIV  = 2'd3;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_e;

  function automatic logic par_bit(input par_e p, input logic [7:0] d);
    case (p)
      PAR_ODD:  par_bit = ~^d;
      PAR_EVEN: par_bit = ^d;
      default:  par_bit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] data,
  input  logic       len8,
  input  par_e       par,
  input  logic       stop2,
  output logic       busy,
  output logic       txd,
  output logic       done
);
  localparam int FRAME_W = 12;
  localparam int OCW     = $clog2(OVS);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [3:0]         left_q, nbits;
  logic [OCW-1:0]     ocnt_q;
  logic [7:0]         dm;

  always_comb begin
    dm = len8 ? data : {1'b0, data[6:0]};
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (len8 || i < 7) frame_d[i+1] = dm[i];
    if (par != PAR_NONE) begin
      if (len8) frame_d[9] = par_bit(par, dm);
      else      frame_d[8] = par_bit(par, dm);
    end
    nbits = 4'd10 - {3'b0, ~len8} + {3'b0, par != PAR_NONE} + {3'b0, stop2};
  end

  assign txd = frame_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      ocnt_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        frame_q <= frame_d;
        left_q  <= nbits;
        ocnt_q  <= '0;
        busy    <= 1'b1;
      end else if (busy && tick) begin
        ocnt_q <= ocnt_q + 1'b1;
        if (ocnt_q == OCW'(OVS - 1)) begin
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          left_q  <= left_q - 1'b1;
          if (left_q == 4'd1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       en,
  input  logic       len8,
  input  par_e       par,
  output logic       done,
  output logic [7:0] chr,
  output logic       perr,
  output logic       ferr
);
  localparam int OCW = $clog2(OVS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_e;

  st_e            st_q;
  logic           s1_q, s2_q;
  logic [OCW-1:0] ocnt_q;
  logic [2:0]     bidx_q;
  logic [7:0]     sh_q;
  logic           len8_q, pbit_q;
  par_e           par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ocnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      len8_q <= 1'b1;
      par_q  <= PAR_NONE;
      pbit_q <= 1'b0;
      done   <= 1'b0;
      chr    <= '1;
      perr   <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st_q)
          S_IDLE: if (en && !s2_q) begin
            st_q   <= S_START;
            ocnt_q <= '0;
            len8_q <= len8;
            par_q  <= par;
          end
          S_START: begin
            ocnt_q <= ocnt_q + 1'b1;
            if (ocnt_q == OCW'(OVS/2 - 1)) begin
              ocnt_q <= '0;
              bidx_q <= '0;
              sh_q   <= '0;
              st_q   <= s2_q ? S_IDLE : S_DATA;
            end
          end
          S_DATA: begin
            ocnt_q <= ocnt_q + 1'b1;
            if (ocnt_q == OCW'(OVS - 1)) begin
              sh_q[bidx_q] <= s2_q;
              bidx_q       <= bidx_q + 1'b1;
              if (bidx_q == (len8_q ? 3'd7 : 3'd6))
                st_q <= (par_q == PAR_NONE) ? S_STOP : S_PAR;
            end
          end
          S_PAR: begin
            ocnt_q <= ocnt_q + 1'b1;
            if (ocnt_q == OCW'(OVS - 1)) begin
              pbit_q <= s2_q;
              st_q   <= S_STOP;
            end
          end
          S_STOP: begin
            ocnt_q <= ocnt_q + 1'b1;
            if (ocnt_q == OCW'(OVS - 1)) begin
              done <= 1'b1;
              chr  <= sh_q;
              perr <= (par_q != PAR_NONE) && (pbit_q != par_bit(par_q, sh_q));
              ferr <= !s2_q;
              st_q <= S_IDLE;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       tx_busy,
  output logic       irq_tx,
  output logic       irq_rx
);
  logic [7:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       rxbuf_q;
  logic             full_q;
  logic [2:0]       stat_q;

  logic tx_tick, rx_tick, tx_go, rd_data, rd_stat;
  logic rx_done, rx_perr, rx_ferr, ovr;
  logic [7:0] rx_chr;

  assign tx_go   = wr_en && (addr == LOC_DATA) && mode_q[7] && !tx_busy;
  assign rd_data = rd_en && (addr == LOC_DATA);
  assign rd_stat = rd_en && (addr == LOC_STAT);
  assign ovr     = full_q && !rd_data;
  assign irq_rx  = rx_done;

  sio_baud #(.DIV_W(DIV_W)) u_tx_baud (
    .clk(clk), .rst_n(rst_n), .clr(tx_go), .div(div_q), .tick(tx_tick)
  );
  sio_baud #(.DIV_W(DIV_W)) u_rx_baud (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .div(div_q), .tick(rx_tick)
  );

  sio_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .load(tx_go), .data(wdata),
    .len8(mode_q[2]), .par(par_e'(mode_q[5:4])), .stop2(mode_q[3]),
    .busy(tx_busy), .txd(txd), .done(irq_tx)
  );

  sio_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rxd(rxd), .en(mode_q[6]),
    .len8(mode_q[2]), .par(par_e'(mode_q[5:4])),
    .done(rx_done), .chr(rx_chr), .perr(rx_perr), .ferr(rx_ferr)
  );

  always_comb begin
    case (addr)
      LOC_DATA: rdata = rxbuf_q;
      LOC_CTRL: rdata = mode_q;
      LOC_STAT: rdata = {4'b0, tx_busy, stat_q};
      default:  rdata = 8'(div_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      div_q   <= '0;
      rxbuf_q <= '1;
      full_q  <= 1'b0;
      stat_q  <= '0;
    end else begin
      if (wr_en && addr == LOC_CTRL) mode_q <= wdata & 8'hFC;
      if (wr_en && addr == LOC_DIV)  div_q  <= DIV_W'(wdata);
      if (rx_done) begin
        rxbuf_q <= rx_chr;
        full_q  <= 1'b1;
      end else if (rd_data) begin
        full_q  <= 1'b0;
      end
      stat_q <= (rd_stat ? 3'b000 : stat_q)
              | (rx_done ? {rx_perr, rx_ferr, ovr} : 3'b000);
    end
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic       txd,
  input logic       tx_busy,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic [7:0] mode_q,
  input logic [2:0] stat_q
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  p_tx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |=> !irq_tx);

  p_rx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);

  p_tx_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> irq_tx);

  p_stat_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2 && !irq_rx) |=> (stat_q == 3'b000));

  p_no_ovr_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && rd_en && addr == 2'd0) |=> $stable(stat_q[0]));

  p_tx_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !mode_q[7] && !tx_busy) |=> !tx_busy);
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .txd(txd), .tx_busy(tx_busy), .irq_tx(irq_tx), .irq_rx(irq_rx),
  .mode_q(mode_q), .stat_q(stat_q)
);

// File: tb/sio_port_tb.sv
module sio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd, tx_busy, irq_tx, irq_rx;
  logic       rxd = 1'b1;

  int nchk = 0, nfail = 0, rxirq = 0;
  int bitclk = 32;
  logic       b_len8 = 1'b1, b_stop2 = 1'b0;
  logic [1:0] b_par = 2'b00;
  logic [8:0] txq[$];
  logic [7:0] v;

  always #2 clk = ~clk;

  sio_port u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .tx_busy(tx_busy), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  always @(posedge clk) if (irq_rx) rxirq++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [1:0] p, input logic [7:0] d);
    if (p == 2'b10) return ~^d;
    if (p == 2'b11) return ^d;
    return 1'b0;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic [7:0] m);
    wr(2'd1, m);
    b_len8 = m[2]; b_stop2 = m[3]; b_par = m[5:4];
  endtask

  // driver: pushes the expected character, checks frame duration (R2, R4)
  task automatic send_tx(input logic [7:0] d);
    logic [7:0] dm;
    int n, cnt;
    dm = b_len8 ? d : {1'b0, d[6:0]};
    txq.push_back({exp_par(b_par, dm), dm});
    n = 1 + (b_len8 ? 8 : 7) + (b_par != 2'b00 ? 1 : 0) + (b_stop2 ? 2 : 1);
    wr(2'd0, d);
    cnt = 0;
    while (tx_busy) begin cnt++; @(negedge clk); end
    chk("R4 busy length", cnt, n * bitclk);
  endtask

  // monitor: decodes frames on txd and compares with the queue (R2 R3 R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        logic [7:0] got;
        logic gp;
        logic [8:0] e;
        got = '0; gp = 1'b0;
        repeat (bitclk/2) @(negedge clk);
        chk("R2 start bit", txd, 1'b0);
        for (int i = 0; i < (b_len8 ? 8 : 7); i++) begin
          repeat (bitclk) @(negedge clk);
          got[i] = txd;
        end
        if (b_par != 2'b00) begin
          repeat (bitclk) @(negedge clk);
          gp = txd;
        end
        repeat (bitclk) @(negedge clk);
        chk("R4 first stop", txd, 1'b1);
        if (b_stop2) begin
          repeat (bitclk) @(negedge clk);
          chk("R4 second stop", txd, 1'b1);
        end
        if (txq.size() == 0) begin
          chk("R7 unexpected frame", 1, 0);
        end else begin
          e = txq.pop_front();
          chk("R2/R5 tx data", got, e[7:0]);
          if (b_par != 2'b00) chk("R3 tx parity", gp, e[8]);
        end
      end
    end
  end

  task automatic send_rx(input logic [7:0] d, input logic len8, input logic [1:0] p,
                         input logic bad_par, input logic bad_stop);
    logic [7:0] dm;
    dm = len8 ? d : {1'b0, d[6:0]};
    @(negedge clk); rxd = 1'b0;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < (len8 ? 8 : 7); i++) begin
      rxd = dm[i];
      repeat (bitclk) @(negedge clk);
    end
    if (p != 2'b00) begin
      rxd = exp_par(p, dm) ^ bad_par;
      repeat (bitclk) @(negedge clk);
    end
    if (bad_stop) begin
      rxd = 1'b0;
      repeat (bitclk/2 + 8) @(negedge clk);
      rxd = 1'b1;
      repeat (bitclk) @(negedge clk);
    end else begin
      rxd = 1'b1;
      repeat (bitclk) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic collide_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    while (!irq_rx) @(negedge clk);
    addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    int k;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(2'd0, v); chk("R1 data reset", v, 8'hFF);
    rd(2'd1, v); chk("R1 ctrl reset", v, 8'h00);
    rd(2'd2, v); chk("R1 status reset", v, 8'h00);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 busy idle", tx_busy, 1'b0);

    wr(2'd3, 8'd1); bitclk = 32;
    set_mode(8'hC4);                 // 8 bit, no parity, one stop
    send_tx(8'hA5);
    send_tx(8'h3C);
    set_mode(8'hFC);                 // even parity, two stops
    send_tx(8'h96);
    set_mode(8'hE0);                 // odd parity, 7 bit
    send_tx(8'hD5);
    set_mode(8'hD4);                 // zero parity
    send_tx(8'hFF);

    // R7: write during busy ignored
    set_mode(8'hC4);
    txq.push_back({1'b0, 8'h5E});
    wr(2'd0, 8'h5E);
    repeat (40) @(negedge clk);
    rd(2'd2, v); chk("R7 status busy bit", v[3], 1'b1);
    wr(2'd0, 8'h81);
    while (tx_busy) @(negedge clk);
    repeat (2*bitclk) @(negedge clk);
    chk("R7 no second frame", tx_busy, 1'b0);
    chk("R7 queue drained", txq.size(), 0);

    // receive
    k = rxirq;
    send_rx(8'h5A, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R11 one rx pulse", rxirq - k, 1);
    rd(2'd0, v); chk("R2 rx data", v, 8'h5A);
    rd(2'd2, v); chk("R9 clean status", v, 8'h00);

    set_mode(8'hF4);                 // even parity, 8 bit
    send_rx(8'h81, 1'b1, 2'b11, 1'b0, 1'b0);
    rd(2'd2, v); chk("R3 good parity", v, 8'h00);
    rd(2'd0, v); chk("R3 rx data", v, 8'h81);
    send_rx(8'h81, 1'b1, 2'b11, 1'b1, 1'b0);
    rd(2'd2, v); chk("R9 parity flag", v, 8'h04);
    rd(2'd2, v); chk("R9 cleared on read", v, 8'h00);
    rd(2'd0, v);
    send_rx(8'h42, 1'b1, 2'b11, 1'b0, 1'b1);
    rd(2'd2, v); chk("R9 framing flag", v, 8'h02);
    rd(2'd0, v);

    set_mode(8'hC0);                 // 7 bit, no parity
    send_rx(8'hD5, 1'b0, 2'b00, 1'b0, 1'b0);
    rd(2'd0, v); chk("R6 7-bit buffer", v, 8'h55);

    set_mode(8'hC4);
    send_rx(8'h11, 1'b1, 2'b00, 1'b0, 1'b0);
    send_rx(8'h22, 1'b1, 2'b00, 1'b0, 1'b0);
    rd(2'd2, v); chk("R9 overrun flag", v, 8'h01);
    rd(2'd0, v); chk("R9 newest kept", v, 8'h22);

    // R8 glitch
    k = rxirq;
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (12*bitclk) @(negedge clk);
    chk("R8 glitch rejected", rxirq - k, 0);
    rd(2'd0, v); chk("R8 buffer unchanged", v, 8'h22);

    // R10 collisions
    set_mode(8'hF4);
    rd(2'd2, v);
    send_rx(8'h11, 1'b1, 2'b11, 1'b0, 1'b0);
    fork
      send_rx(8'h22, 1'b1, 2'b11, 1'b1, 1'b0);
      collide_read(2'd0, v);
    join
    chk("R10 data read returns old", v, 8'h11);
    rd(2'd2, v); chk("R10 no overrun on read", v, 8'h04);
    rd(2'd0, v); chk("R10 new char", v, 8'h22);
    fork
      send_rx(8'h33, 1'b1, 2'b11, 1'b1, 1'b0);
      collide_read(2'd2, v);
    join
    chk("R10 status read returns old", v, 8'h00);
    rd(2'd2, v); chk("R10 flag survives", v, 8'h04);
    rd(2'd0, v);

    // R12 disables
    set_mode(8'h44);
    wr(2'd0, 8'h77);
    chk("R12 tx disabled", tx_busy, 1'b0);
    repeat (bitclk) @(negedge clk);
    chk("R12 line idle", txd, 1'b1);
    set_mode(8'h84);
    k = rxirq;
    send_rx(8'h99, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R12 rx disabled", rxirq - k, 0);
    rd(2'd0, v); chk("R12 buffer kept", v, 8'h33);
    chk("R2 queue empty", txq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule